// File: doc/BRIEF.md
# Systolic Three-Tap Convolution Array

This block computes a three-weight sliding dot product over a stream of signed samples. For every window of three consecutive samples x_i, x_(i+1), x_(i+2) it produces y_i = w1·x_i + w2·x_(i+1) + w3·x_(i+2). The weights are held in a chain of three processing cells, one weight per cell. Samples move through the chain at half the speed of the partial sums: two registers per cell for a sample and one for a partial sum. As a result, each partial sum meets the three samples of its window in turn. Each sample is presented once at the input and is then reused by every cell.

Inside each cell the multiply and the accumulate are separate register stages. The product of one sample is therefore added while the next sample is being multiplied. Each cell keeps two weight banks. Every sample carries a one-bit bank select, and every cell weights that sample from the bank it carries. This lets the weights be switched between neighbouring samples without a stall.

Weights are written serially through a load port while the stream is idle. A result appears a fixed number of cycles after the last sample of its window. The output valid flag marks only windows of three back-to-back valid samples.

Top module: `sconv_array`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid` low and `out_data` zero. All weights also clear to zero.
- R2: If samples are taken at edges g-5, g-4 and g-3, the result after edge g is w1·x(g-5) + w2·x(g-4) + w3·x(g-3). The result therefore leaves three edges after the last sample of its window is taken.
- R3: Samples and weights are 16-bit two's complement. The result is the exact 36-bit signed sum, including for the most negative and most positive operands.
- R4: After edge g, `out_valid` is high exactly when `in_valid` was high at all three edges g-5, g-4 and g-3. A gap in the input suppresses every window that contains it.
- R5: `in_bank` is taken together with its sample: 0 selects bank 0 and 1 selects bank 1. Each cell multiplies that sample by its weight from the selected bank, so a change of select applies from the next sample on.
- R6: A word on `wload_data` is accepted at each edge where `wload_en` is high and the array is idle. Each accepted word shifts the six weight slots. After six loads the order of arrival is bank 0 w1, w2, w3, then bank 1 w1, w2, w3.
- R7: `wload_en` has no effect at an edge where `in_valid` is high or any sample is still inside the array. The weights then stay as they were.
- R8: A run of N back-to-back valid samples gives N-2 back-to-back valid results, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is present this cycle |
| in_sample | input | 16 | Signed sample |
| in_bank | input | 1 | Weight bank used for this sample |
| wload_en | input | 1 | Weight load strobe |
| wload_data | input | 16 | Signed weight word |
| out_valid | output | 1 | Result valid |
| out_data | output | 36 | Signed result |

## Verification
An ascending ramp with distinct weights in every slot shows whether each tap lines up with the right sample and whether results arrive at the right cycle. A ramp with the taps swapped or shifted by one cycle gives different numbers. A valid pattern with single and double gaps separates a window-based valid flag from a plain delayed copy of the input valid. Streams that alternate banks per sample show whether the select travels with its sample or is taken globally. Full-scale operands of both signs expose truncation or lost sign extension. A load strobe held during a stream, followed by a stream that reuses the same weights, shows whether the weights were corrupted.

// File: rtl/sconv_pkg.sv
package sconv_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int COEF_W    = 16;
    localparam int PROD_W    = SAMPLE_W + COEF_W;
    localparam int ACC_W     = 36;
    localparam int NUM_BANKS = 2;
    localparam int BANK_W    = 1;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [PROD_W-1:0]   prod_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    // sample token moving along the slow path
    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        sample_t           smp;
    } xtok_t;

    // partial-sum token moving along the fast path
    typedef struct packed {
        logic vld;
        acc_t acc;
    } ytok_t;

    // slot of (bank, tap) in the serial weight chain, tap counted from 1
    function automatic int coef_slot(input int bank, input int tap, input int taps);
        return bank * taps + tap - 1;
    endfunction

    function automatic acc_t widen(input prod_t p);
        return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction

endpackage

// File: rtl/sconv_coef_chain.sv
module sconv_coef_chain
    import sconv_pkg::*;
#(
    parameter int TAPS = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_en,
    input  logic  ld_block,
    input  coef_t ld_data,
    output coef_t [NUM_BANKS*TAPS-1:0] slots
);
    localparam int SLOTS = NUM_BANKS * TAPS;

    coef_t [SLOTS-1:0] slots_q;
    logic              take;

    assign take  = ld_en && !ld_block;
    assign slots = slots_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
        end else if (take) begin
            for (int j = 0; j < SLOTS-1; j++) begin
                slots_q[j] <= slots_q[j+1];
            end
            slots_q[SLOTS-1] <= ld_data;
        end
    end

    // R6: an accepted word lands in the newest slot, older words move down
    p_load_shift_r6: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !ld_block) |=> (slots[SLOTS-1] == $past(ld_data)) && (slots[0] == $past(slots[1])));

    // R7: a strobe while busy leaves every weight untouched
    p_load_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_block) |=> $stable(slots));

endmodule

// File: rtl/sconv_cell.sv
module sconv_cell
    import sconv_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  coef_t [NUM_BANKS-1:0]   coefs,
    input  xtok_t                   x_in,
    output xtok_t                   x_out,
    input  ytok_t                   y_in,
    output ytok_t                   y_out,
    output logic                    busy
);
    xtok_t xs_a, xs_b;
    prod_t prod_q, prod_d;
    logic  prod_vld_q;
    ytok_t y_q;

    // multiply stage operand: weight from the bank the sample carries
    always_comb begin
        prod_d = prod_t'(coefs[x_in.bank]) * prod_t'(x_in.smp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xs_a       <= '0;
            xs_b       <= '0;
            prod_q     <= '0;
            prod_vld_q <= 1'b0;
            y_q        <= '0;
        end else begin
            xs_a       <= x_in;
            xs_b       <= xs_a;
            prod_vld_q <= x_in.vld;
            prod_q     <= x_in.vld ? prod_d : '0;
            y_q.vld    <= y_in.vld && prod_vld_q;
            y_q.acc    <= y_in.acc + widen(prod_q);
        end
    end

    assign x_out = xs_b;
    assign y_out = y_q;
    assign busy  = xs_a.vld || xs_b.vld || prod_vld_q || y_q.vld;

    // R2: a sample leaves the cell unchanged two edges after entering it
    p_sample_travel_r2: assert property (@(posedge clk) disable iff (rst)
        x_out.vld |-> ($past(x_in.vld, 2) && (x_out == $past(x_in, 2))));

    // R4: a valid partial sum needs a valid sample at this cell two edges before
    p_sum_needs_sample_r4: assert property (@(posedge clk) disable iff (rst)
        y_out.vld |-> $past(x_in.vld, 2));

endmodule

// File: rtl/sconv_array.sv
module sconv_array
    import sconv_pkg::*;
#(
    parameter int TAPS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                in_bank,
    input  logic                wload_en,
    input  logic [COEF_W-1:0]   wload_data,
    output logic                out_valid,
    output logic [ACC_W-1:0]    out_data
);
    localparam int SLOTS = NUM_BANKS * TAPS;

    xtok_t            xt [TAPS+1];
    ytok_t            yt [TAPS+1];
    logic [TAPS-1:0]  cell_busy;
    coef_t [SLOTS-1:0] slots;
    logic             ld_block;
    logic             unused_tail;

    assign xt[0].vld  = in_valid;
    assign xt[0].bank = in_bank;
    assign xt[0].smp  = sample_t'(in_sample);
    assign yt[0].vld  = 1'b1;
    assign yt[0].acc  = '0;

    assign ld_block = in_valid || (|cell_busy);

    sconv_coef_chain #(.TAPS(TAPS)) coef_i (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (wload_en),
        .ld_block (ld_block),
        .ld_data  (coef_t'(wload_data)),
        .slots    (slots)
    );

    // cell c holds tap TAPS-c: partial sums outrun samples, so the order is reversed
    for (genvar c = 0; c < TAPS; c++) begin : g_cell
        coef_t [NUM_BANKS-1:0] cell_coefs;
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign cell_coefs[b] = slots[coef_slot(b, TAPS - c, TAPS)];
        end
        sconv_cell cell_i (
            .clk   (clk),
            .rst   (rst),
            .coefs (cell_coefs),
            .x_in  (xt[c]),
            .x_out (xt[c+1]),
            .y_in  (yt[c]),
            .y_out (yt[c+1]),
            .busy  (cell_busy[c])
        );
    end

    assign unused_tail = ^xt[TAPS];
    assign out_valid   = yt[TAPS].vld;
    assign out_data    = yt[TAPS].acc;

    // R1: reset clears the output on the following cycle
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_data == '0)));

    // R7: while samples are in flight the weights cannot move
    p_weights_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (|cell_busy) |=> $stable(slots));

endmodule

// File: tb/sconv_array_tb_top.sv
module sconv_array_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_sample;
    logic        in_bank;
    logic        wload_en;
    logic [15:0] wload_data;
    logic        out_valid;
    logic [35:0] out_data;

    always #5 clk = ~clk;

    sconv_array #(.TAPS(3)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .in_bank    (in_bank),
        .wload_en   (wload_en),
        .wload_data (wload_data),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    int     n_checks = 0;
    int     n_errors = 0;
    int     out_seen = 0;
    bit     chk_on   = 1'b0;
    bit     done     = 1'b0;
    string  phase_req = "R2";

    // behavioural model: sample history (newest first) and six weight slots
    longint hx[$];
    bit     hv[$];
    bit     hb[$];
    longint wq[6];

    always @(posedge clk) begin
        if (rst) begin
            hx = {};
            hv = {};
            hb = {};
            for (int i = 0; i < 6; i++) begin
                hx.push_front(0);
                hv.push_front(1'b0);
                hb.push_front(1'b0);
                wq[i] = 0;
            end
        end else begin
            if (wload_en && !in_valid) begin
                for (int j = 0; j < 5; j++) wq[j] = wq[j+1];
                wq[5] = longint'($signed(wload_data));
            end
            hx.push_front(longint'($signed(in_sample)));
            hv.push_front(in_valid);
            hb.push_front(in_bank);
            void'(hx.pop_back());
            void'(hv.pop_back());
            void'(hb.pop_back());
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !rst) begin
            bit     ev;
            longint ed;
            ev = hv[3] && hv[4] && hv[5];
            ed = wq[hb[5]*3 + 0] * hx[5] + wq[hb[4]*3 + 1] * hx[4] + wq[hb[3]*3 + 2] * hx[3];
            check("R4", longint'(out_valid), longint'(ev));
            if (ev && out_valid) begin
                check(phase_req, longint'($signed(out_data)), ed);
            end
            if (out_valid) out_seen++;
        end
    end

    task automatic drive(input bit v, input int s, input bit b);
        in_valid  = v;
        in_sample = 16'(s);
        in_bank   = b;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        wload_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic load_word(input int d);
        wload_en   = 1'b1;
        wload_data = 16'(d);
        @(negedge clk);
        wload_en   = 1'b0;
    endtask

    task automatic load_all(input int a0, input int a1, input int a2,
                            input int b0, input int b1, input int b2);
        load_word(a0); load_word(a1); load_word(a2);
        load_word(b0); load_word(b1); load_word(b2);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst        = 1'b1;
        in_valid   = 1'b0;
        in_sample  = '0;
        in_bank    = 1'b0;
        wload_en   = 1'b0;
        wload_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", longint'(out_valid), 0);
        check("R1", longint'(out_data), 0);
        rst    = 1'b0;
        chk_on = 1'b1;
        idle(2);

        // R6: serial load order, distinct values per slot
        phase_req = "R6";
        load_all(1, 2, 3, -5, 7, 11);
        idle(2);

        // R2 and R8: contiguous ascending ramp on bank 0
        phase_req = "R2";
        out_seen  = 0;
        for (int i = 1; i <= 12; i++) drive(1'b1, i, 1'b0);
        idle(8);
        check("R8", out_seen, 10);

        // R4: gaps in the valid pattern
        phase_req = "R4";
        begin
            bit vp[12] = '{1,1,0,1,1,1,0,0,1,1,1,1};
            for (int i = 0; i < 12; i++) drive(vp[i], 40 - 7*i, 1'b0);
        end
        idle(8);

        // R5: per-sample bank select
        phase_req = "R5";
        begin
            bit bp[10] = '{0,1,1,0,1,0,0,1,0,1};
            for (int i = 0; i < 10; i++) drive(1'b1, 3 + 13*i - i*i, bp[i]);
        end
        idle(8);

        // R3: full-scale operands of both signs
        phase_req = "R3";
        load_all(-32768, -32768, -32768, 32767, 32767, 32767);
        idle(2);
        for (int i = 0; i < 4; i++) drive(1'b1, -32768, 1'b0);
        for (int i = 0; i < 4; i++) drive(1'b1, 32767, 1'b1);
        for (int i = 0; i < 4; i++) drive(1'b1, -32768, 1'b1);
        for (int i = 0; i < 4; i++) drive(1'b1, 32767, 1'b0);
        idle(8);

        // R7: load strobes during a stream are ignored
        phase_req = "R7";
        load_all(4, -3, 9, 6, -2, 5);
        idle(2);
        wload_en   = 1'b1;
        wload_data = 16'd999;
        for (int i = 0; i < 10; i++) drive(1'b1, 5*i - 20, i[0]);
        wload_en = 1'b0;
        idle(8);
        for (int i = 0; i < 8; i++) drive(1'b1, 17 - 3*i, i[1]);
        idle(8);

        done = 1'b1;
        finish_run();
    end

endmodule